// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block joins two byte-wide ports, A and B, through two storage paths that do not depend on each other. One path carries data from A to B and the other from B to A. Each path has three active-low controls: a path enable, a latch enable and an output enable. With these controls a path can pass its source straight through to its destination, freeze a value and keep showing it, or release its destination port while still holding or capturing data.

Tri-state ports appear as separate data-in, data-out and drive-enable signals, so the block contains no bidirectional nets. The pad ring or the bus fabric merges these signals. Level-sensitive latching is built from a clocked register plus a bypass mux. While the latch is open, the register reloads on every clock edge, and the destination sees the source with no delay. The register keeps the last value it loaded before the latch closed. A flag reports when both ports are driven at the same time, which is an illegal setup.

Top module: `dual_latch_xcvr`

## Requirements
- R1: While the synchronous reset `rst_n` is low, `a_oe` and `b_oe` are 0 whatever the controls are. Once reset is released, both stored bytes read back as 8'h00.
- R2: When `ab_en_n`, `ab_le_n` and `ab_oe_n` are all 0, `b_oe` is 1 and `b_o` equals `a_i` in the same cycle.
- R3: If `ab_le_n` goes from 0 to 1 while `ab_en_n` stays 0, the path stores the `a_i` value that was present at the last clock edge with the latch open, and `b_o` then shows that value.
- R4: If `ab_en_n` goes from 0 to 1 while `ab_le_n` is 0, the path also captures. The stored value appears on `b_o` once `ab_en_n` is low again and `ab_le_n` is high.
- R5: While the A-to-B latch is closed, changes on `a_i` have no effect on `b_o`.
- R6: When `ab_oe_n` is 1, `b_oe` is 0. The latch still opens and captures in this state, and the captured byte appears once `ab_oe_n` returns to 0.
- R7: When `ab_en_n` is 1, `b_oe` is 0 and the A-to-B latch does not follow `a_i`.
- R8: The B-to-A path follows R2 to R7 using `ba_en_n`, `ba_le_n` and `ba_oe_n`, with `b_i` as its source and `a_o`/`a_oe` as its destination. Its storage is separate from the A-to-B storage.
- R9: `contention` is 1 exactly when `a_oe` and `b_oe` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latch emulation |
| rst_n | input | 1 | Synchronous active-low reset |
| a_i | input | 8 | Value currently on port A |
| b_i | input | 8 | Value currently on port B |
| ab_en_n | input | 1 | A-to-B path enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_en_n | input | 1 | B-to-A path enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_o | output | 8 | Data driven onto port A |
| a_oe | output | 1 | Port A driver enable |
| b_o | output | 8 | Data driven onto port B |
| b_oe | output | 1 | Port B driver enable |
| contention | output | 1 | Both ports driven at once |

## Verification
Each direction runs through twelve control patterns in turn: transparent pass, capture by the latch enable, hold while the source changes, released port while latching, and capture by the path enable. Every source byte differs from the byte held before it. A path that stays transparent when it should hold, or that captures one cycle late, therefore shows the wrong byte on the destination. The two directions use disjoint data sets. This exposes a swapped or shared store. A contention pattern and a reset in the middle of the run separate the reset clearing from the normal hold behaviour.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef struct packed {
      logic en_n;
      logic le_n;
      logic oe_n;
   } ctrl_t;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int W = 8,
   parameter bit FLOW_THROUGH = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_n,
   input  logic         le_n,
   input  logic [W-1:0] src,
   output logic [W-1:0] lat
);
   logic         open_w;
   logic [W-1:0] q;

   generate
      if (W < 1) begin : g_bad_w
         $error("xcvr_store: W must be at least 1");
      end
   endgenerate

   assign open_w = rst_n & ~(en_n | le_n);

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (open_w) q <= src;
   end

   generate
      if (FLOW_THROUGH) begin : g_flow
         assign lat = open_w ? src : q;
      end else begin : g_reg
         assign lat = q;
      end
   endgenerate

   // R3
   store_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n && !le_n) |=> q == $past(src));
   // R5
   store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n || le_n) |=> q == $past(q));
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
   parameter int W = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic         rst_n,
   input  logic         en_n,
   input  logic         oe_n,
   input  logic [W-1:0] lat,
   output logic [W-1:0] dst_o,
   output logic         dst_oe
);
   assign dst_oe = rst_n & ~(en_n | oe_n);

   generate
      if (PARK_ZERO) begin : g_park
         assign dst_o = dst_oe ? lat : '0;
      end else begin : g_raw
         assign dst_o = lat;
      end
   endgenerate
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
   import xcvr_pkg::*;
#(
   parameter int W = 8,
   parameter bit FLOW_THROUGH = 1'b1,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  ctrl_t        ctl,
   input  logic [W-1:0] src,
   output logic [W-1:0] dst_o,
   output logic         dst_oe
);
   logic [W-1:0] lat;

   xcvr_store #(.W(W), .FLOW_THROUGH(FLOW_THROUGH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .en_n  (ctl.en_n),
      .le_n  (ctl.le_n),
      .src   (src),
      .lat   (lat)
   );

   xcvr_drive #(.W(W), .PARK_ZERO(PARK_ZERO)) u_drive (
      .rst_n  (rst_n),
      .en_n   (ctl.en_n),
      .oe_n   (ctl.oe_n),
      .lat    (lat),
      .dst_o  (dst_o),
      .dst_oe (dst_oe)
   );
endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
   import xcvr_pkg::*;
#(
   parameter int W = 8,
   parameter bit FLOW_THROUGH = 1'b1,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         ab_en_n,
   input  logic         ab_le_n,
   input  logic         ab_oe_n,
   input  logic         ba_en_n,
   input  logic         ba_le_n,
   input  logic         ba_oe_n,
   output logic [W-1:0] a_o,
   output logic         a_oe,
   output logic [W-1:0] b_o,
   output logic         b_oe,
   output logic         contention
);
   ctrl_t ab_ctl, ba_ctl;

   assign ab_ctl = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
   assign ba_ctl = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};

   xcvr_path #(.W(W), .FLOW_THROUGH(FLOW_THROUGH), .PARK_ZERO(PARK_ZERO)) u_ab (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ab_ctl),
      .src    (a_i),
      .dst_o  (b_o),
      .dst_oe (b_oe)
   );

   xcvr_path #(.W(W), .FLOW_THROUGH(FLOW_THROUGH), .PARK_ZERO(PARK_ZERO)) u_ba (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ba_ctl),
      .src    (b_i),
      .dst_o  (a_o),
      .dst_oe (a_oe)
   );

   assign contention = a_oe & b_oe;

   // R1
   always_comb begin
      if (!rst_n) begin
         rst_release_chk: assert (!a_oe && !b_oe);
      end
   end

   // R2
   ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_en_n && !ab_le_n && !ab_oe_n) |-> (b_oe && b_o == a_i));
   // R8
   ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_en_n && !ba_le_n && !ba_oe_n) |-> (a_oe && a_o == b_i));
   // R6
   ab_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ab_oe_n |-> !b_oe);
   // R7
   ab_en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ab_en_n |-> !b_oe);
   // R9
   contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      contention |-> (!ab_en_n && !ab_oe_n && !ba_en_n && !ba_oe_n));
endmodule

// File: tb/sim_dual_latch_xcvr.sv
module sim_dual_latch_xcvr;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] a_i, b_i;
   logic       ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;
   logic [7:0] a_o, b_o;
   logic       a_oe, b_oe, contention;
   int         checks = 0;
   int         errors = 0;

   always #(CLK_P/2) clk = ~clk;

   dual_latch_xcvr u0 (
      .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i),
      .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
      .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
      .a_o(a_o), .a_oe(a_oe), .b_o(b_o), .b_oe(b_oe), .contention(contention)
   );

   // {dir, en_n, le_n, oe_n, src, exp_oe, exp_val, req}
   localparam logic [24:0] VEC [24] = '{
      {1'b0, 3'b000, 8'h3C, 1'b1, 8'h3C, 4'd2},  // R2 transparent
      {1'b0, 3'b000, 8'hA5, 1'b1, 8'hA5, 4'd2},  // R2
      {1'b0, 3'b010, 8'h0F, 1'b1, 8'hA5, 4'd3},  // R3 capture by latch enable
      {1'b0, 3'b010, 8'hF0, 1'b1, 8'hA5, 4'd5},  // R5 hold
      {1'b0, 3'b011, 8'hF0, 1'b0, 8'h00, 4'd6},  // R6 released
      {1'b0, 3'b001, 8'h5A, 1'b0, 8'h00, 4'd6},  // R6 latching while released
      {1'b0, 3'b011, 8'h11, 1'b0, 8'h00, 4'd6},  // R6
      {1'b0, 3'b010, 8'h22, 1'b1, 8'h5A, 4'd6},  // R6 shows captured byte
      {1'b0, 3'b000, 8'h77, 1'b1, 8'h77, 4'd2},  // R2
      {1'b0, 3'b100, 8'h99, 1'b0, 8'h00, 4'd7},  // R7 path enable high
      {1'b0, 3'b100, 8'h66, 1'b0, 8'h00, 4'd7},  // R7
      {1'b0, 3'b010, 8'h44, 1'b1, 8'h77, 4'd4},  // R4 capture by path enable
      {1'b1, 3'b000, 8'h81, 1'b1, 8'h81, 4'd8},  // R8 B-to-A rows
      {1'b1, 3'b000, 8'h18, 1'b1, 8'h18, 4'd8},
      {1'b1, 3'b010, 8'hE7, 1'b1, 8'h18, 4'd8},
      {1'b1, 3'b010, 8'h7E, 1'b1, 8'h18, 4'd8},
      {1'b1, 3'b011, 8'h7E, 1'b0, 8'h00, 4'd8},
      {1'b1, 3'b001, 8'hC3, 1'b0, 8'h00, 4'd8},
      {1'b1, 3'b011, 8'hDB, 1'b0, 8'h00, 4'd8},
      {1'b1, 3'b010, 8'hBD, 1'b1, 8'hC3, 4'd8},
      {1'b1, 3'b000, 8'h2D, 1'b1, 8'h2D, 4'd8},
      {1'b1, 3'b100, 8'hD2, 1'b0, 8'h00, 4'd8},
      {1'b1, 3'b100, 8'hB4, 1'b0, 8'h00, 4'd8},
      {1'b1, 3'b010, 8'h4B, 1'b1, 8'h2D, 4'd8}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_P * 5000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; a_i = 8'h55; b_i = 8'hAA;
      {ab_en_n, ab_le_n, ab_oe_n} = 3'b000;
      {ba_en_n, ba_le_n, ba_oe_n} = 3'b000;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R1 b_oe in reset", {7'd0, b_oe}, 8'd0);
      chk("R1 a_oe in reset", {7'd0, a_oe}, 8'd0);
      rst_n = 1'b1;
      {ab_en_n, ab_le_n, ab_oe_n} = 3'b010;
      {ba_en_n, ba_le_n, ba_oe_n} = 3'b110;
      #1;
      chk("R1 A-to-B store cleared", b_o, 8'h00);
      @(negedge clk);
      {ab_en_n, ab_le_n, ab_oe_n} = 3'b110;
      {ba_en_n, ba_le_n, ba_oe_n} = 3'b010;
      #1;
      chk("R1 B-to-A store cleared", a_o, 8'h00);

      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         if (!VEC[i][24]) begin
            {ab_en_n, ab_le_n, ab_oe_n} = VEC[i][23:21];
            {ba_en_n, ba_le_n, ba_oe_n} = 3'b111;
            a_i = VEC[i][20:13]; b_i = ~VEC[i][20:13];
         end else begin
            {ba_en_n, ba_le_n, ba_oe_n} = VEC[i][23:21];
            {ab_en_n, ab_le_n, ab_oe_n} = 3'b111;
            b_i = VEC[i][20:13]; a_i = ~VEC[i][20:13];
         end
         #1;
         if (!VEC[i][24]) begin
            chk($sformatf("R%0d row %0d oe", VEC[i][3:0], i), {7'd0, b_oe}, {7'd0, VEC[i][12]});
            if (VEC[i][12]) chk($sformatf("R%0d row %0d data", VEC[i][3:0], i), b_o, VEC[i][11:4]);
         end else begin
            chk($sformatf("R%0d row %0d oe", VEC[i][3:0], i), {7'd0, a_oe}, {7'd0, VEC[i][12]});
            if (VEC[i][12]) chk($sformatf("R%0d row %0d data", VEC[i][3:0], i), a_o, VEC[i][11:4]);
         end
         chk("R9 no contention", {7'd0, contention}, 8'd0);
      end

      // R9 and R8: both ports driven, each shows its own held byte
      @(negedge clk);
      {ab_en_n, ab_le_n, ab_oe_n} = 3'b010;
      {ba_en_n, ba_le_n, ba_oe_n} = 3'b010;
      #1;
      chk("R9 contention flagged", {7'd0, contention}, 8'd1);
      chk("R8 A-to-B held byte", b_o, 8'h77);
      chk("R8 B-to-A held byte", a_o, 8'h2D);
      @(negedge clk);
      ba_oe_n = 1'b1;
      #1;
      chk("R9 contention cleared", {7'd0, contention}, 8'd0);

      // R1 reset in mid-run clears both stores
      @(negedge clk);
      rst_n = 1'b0; ba_oe_n = 1'b0;
      #1;
      chk("R1 b_oe forced off", {7'd0, b_oe}, 8'd0);
      chk("R1 a_oe forced off", {7'd0, a_oe}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1; ba_oe_n = 1'b1;
      #1;
      chk("R1 A-to-B cleared after run", b_o, 8'h00);
      @(negedge clk);
      ab_oe_n = 1'b1; ba_oe_n = 1'b0;
      #1;
      chk("R1 B-to-A cleared after run", a_o, 8'h00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule